// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a write-back, write-allocate data cache built around a direct-mapped line array, backed by a small fully associative side store that catches lines pushed out of the array. A block address selects one array line through its low bits. Every line carries a valid flag, a dirty flag, a tag and one data word. When the array misses, every side-store entry is compared against the full block address in the same cycle. A match swaps the two lines, so the requested block returns to the array and the line it displaces moves into the side store. This costs one cycle more than an array hit.

When both stores miss, the block is read from memory into the array. The valid line it replaces moves into the side store. If the side store is full, its least recently written entry is dropped to make room, and that entry is first written to memory when it is dirty. The processor holds a request, with address and write data stable, until the cache reports a hit. The memory side uses a single request/acknowledge handshake for both reads and writes.

Top module: `victim_dm_cache`

## Requirements
- R1: Array line index = block address mod 2^IDX_W, and tag = the remaining upper bits. A request that matches a valid array line completes in the same cycle (cpu_hit_o high, cpu_rdata_o holding the line's word) without a memory request.
- R2: A write that hits the array updates the word and marks the line dirty. It takes zero wait cycles and issues no memory traffic.
- R3: A request that misses both stores issues one memory read of its own address. cpu_hit_o rises in the cycle after mem_ack_i, with the fetched word.
- R4: When a fill replaces a valid array line, that line is moved into the side store without any memory write.
- R5: A side-store hit issues no memory request and completes exactly one cycle after the request appears. It returns the block's latest data, including data written earlier. The displaced array line enters the side store.
- R6: The side store holds VICT_N (4) entries, searched in parallel by full block address. Four evicted blocks that share one array index all stay reachable.
- R7: The side-store entry written least recently is the one replaced when the store is full. Empty entries are used first.
- R8: A dirty entry pushed out of the side store is written to memory (mem_we_o=1, its address and data) before the refill read. A clean entry pushed out causes no write.
- R9: mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o stay stable from the rise of mem_req_o until the cycle mem_ack_i is high.
- R10: After rst_ni, all lines and entries are invalid and no memory request is pending. The first access to any address misses.
- R11: cpu_stall_o is high in every cycle in which cpu_req_i is high and cpu_hit_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until cpu_hit_o |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Block (word) address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_hit_o |
| cpu_hit_o | output | 1 | Request completes this cycle |
| cpu_stall_o | output | 1 | Request pending and not completing |
| mem_req_o | output | 1 | Memory request, held until mem_ack_i |
| mem_we_o | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr_o | output | ADDR_W | Memory block address |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_ack_i | input | 1 | Memory completes the request this cycle |
| mem_rdata_i | input | DATA_W | Refill data, valid with mem_ack_i |

## Verification
The bench drives chains of blocks that all map to one array index. This checks that a swap returns dirty data intact; a swap that lost the dirty flag or the word would return stale data or miss the later write-back. It fills the side store and then forces one more conflict. The bench expects one write of the oldest dirty block in a six-cycle miss, followed by the clean oldest block dropping with no write. A design with a wrong age order would drop a block that later still hits, or would write the wrong address. After a reset, the first access must go to memory and return the written-back data; a store whose valid flags survived reset would answer from the array instead.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_LOOK = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned TAG_W  = 9,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_dirty_i
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/vc_victim_store.sv
module vc_victim_store #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  look_addr_i,
  output logic [ENTRIES-1:0] hit_vec_o,
  output logic               hit_o,
  output logic [SLOT_W-1:0]  hit_slot_o,
  output logic [DATA_W-1:0]  hit_data_o,
  output logic               hit_dirty_o,
  output logic [SLOT_W-1:0]  sel_slot_o,
  output logic               sel_valid_o,
  output logic               sel_dirty_o,
  output logic [ADDR_W-1:0]  sel_addr_o,
  output logic [DATA_W-1:0]  sel_data_o,
  input  logic               wr_en_i,
  input  logic [SLOT_W-1:0]  wr_slot_i,
  input  logic               wr_valid_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               wr_dirty_i
);
  logic [ENTRIES-1:0] valid_q, dirty_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [SLOT_W-1:0]  age_q  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_q[g] && (addr_q[g] == look_addr_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_slot_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) hit_slot_o = SLOT_W'(i);
    end
  end

  assign hit_data_o  = data_q[hit_slot_o];
  assign hit_dirty_o = dirty_q[hit_slot_o];

  // empty entry first, otherwise the oldest one
  always_comb begin
    logic found;
    found      = 1'b0;
    sel_slot_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_q[i] && !found) begin
        sel_slot_o = SLOT_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age_q[i] == SLOT_W'(ENTRIES - 1)) sel_slot_o = SLOT_W'(i);
      end
    end
  end

  assign sel_valid_o = valid_q[sel_slot_o];
  assign sel_dirty_o = dirty_q[sel_slot_o];
  assign sel_addr_o  = addr_q[sel_slot_o];
  assign sel_data_o  = data_q[sel_slot_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_slot_i] <= wr_valid_i;
      dirty_q[wr_slot_i] <= wr_valid_i && wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= SLOT_W'(i);
    end else if (wr_en_i && wr_valid_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (SLOT_W'(i) == wr_slot_i)           age_q[i] <= '0;
        else if (age_q[i] < age_q[wr_slot_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      addr_q[wr_slot_i] <= wr_addr_i;
      data_q[wr_slot_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic main_hit_i,
  input  logic vict_hit_i,
  input  logic need_wb_i,
  input  logic mem_ack_i,
  output logic hit_o,
  output logic swap_o,
  output logic fill_o,
  output logic mem_req_o,
  output logic mem_we_o
);
  vc_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    hit_o     = 1'b0;
    swap_o    = 1'b0;
    fill_o    = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    unique case (state_q)
      ST_LOOK: begin
        if (req_i) begin
          if (main_hit_i)      hit_o  = 1'b1;
          else if (vict_hit_i) swap_o = 1'b1;
          else                 state_d = need_wb_i ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        fill_o    = mem_ack_i;
        if (mem_ack_i) state_d = ST_LOOK;
      end
      default: state_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOOK;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/victim_dm_cache.sv
module victim_dm_cache #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned VICT_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_hit_o,
  output logic              cpu_stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned TAG_W  = ADDR_W - IDX_W;
  localparam int unsigned SLOT_W = $clog2(VICT_N);

  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag;
  logic [DATA_W-1:0] m_data;
  logic              m_wr_en, m_wr_dirty;
  logic [DATA_W-1:0] m_wr_data;

  logic [VICT_N-1:0] v_hit_vec;
  logic              v_hit, v_hit_dirty, v_sel_valid, v_sel_dirty;
  logic [SLOT_W-1:0] v_hit_slot, v_sel_slot;
  logic [DATA_W-1:0] v_hit_data, v_sel_data;
  logic [ADDR_W-1:0] v_sel_addr;
  logic              v_wr_en;

  logic main_hit, need_wb, hit, swap_en, fill_en;

  assign cur_idx = cpu_addr_i[IDX_W-1:0];
  assign cur_tag = cpu_addr_i[ADDR_W-1:IDX_W];

  vc_main_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_main (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (cur_idx),
    .rd_valid_o (m_valid),
    .rd_dirty_o (m_dirty),
    .rd_tag_o   (m_tag),
    .rd_data_o  (m_data),
    .wr_en_i    (m_wr_en),
    .wr_idx_i   (cur_idx),
    .wr_tag_i   (cur_tag),
    .wr_data_i  (m_wr_data),
    .wr_dirty_i (m_wr_dirty)
  );

  vc_victim_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(VICT_N)) u_vict (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_addr_i (cpu_addr_i),
    .hit_vec_o   (v_hit_vec),
    .hit_o       (v_hit),
    .hit_slot_o  (v_hit_slot),
    .hit_data_o  (v_hit_data),
    .hit_dirty_o (v_hit_dirty),
    .sel_slot_o  (v_sel_slot),
    .sel_valid_o (v_sel_valid),
    .sel_dirty_o (v_sel_dirty),
    .sel_addr_o  (v_sel_addr),
    .sel_data_o  (v_sel_data),
    .wr_en_i     (v_wr_en),
    .wr_slot_i   (swap_en ? v_hit_slot : v_sel_slot),
    .wr_valid_i  (m_valid),
    .wr_addr_i   ({m_tag, cur_idx}),
    .wr_data_i   (m_data),
    .wr_dirty_i  (m_dirty)
  );

  assign main_hit = m_valid && (m_tag == cur_tag);
  // a push-out only happens when a valid line must enter a full slot
  assign need_wb  = m_valid && v_sel_valid && v_sel_dirty;

  vc_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (cpu_req_i),
    .main_hit_i (main_hit),
    .vict_hit_i (v_hit),
    .need_wb_i  (need_wb),
    .mem_ack_i  (mem_ack_i),
    .hit_o      (hit),
    .swap_o     (swap_en),
    .fill_o     (fill_en),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o)
  );

  always_comb begin
    m_wr_en    = 1'b0;
    m_wr_data  = m_data;
    m_wr_dirty = m_dirty;
    if (hit && cpu_we_i) begin
      m_wr_en    = 1'b1;
      m_wr_data  = cpu_wdata_i;
      m_wr_dirty = 1'b1;
    end else if (swap_en) begin
      m_wr_en    = 1'b1;
      m_wr_data  = v_hit_data;
      m_wr_dirty = v_hit_dirty;
    end else if (fill_en) begin
      m_wr_en    = 1'b1;
      m_wr_data  = mem_rdata_i;
      m_wr_dirty = 1'b0;
    end
  end

  assign v_wr_en = swap_en || (fill_en && m_valid);

  assign mem_addr_o  = mem_we_o ? v_sel_addr : cpu_addr_i;
  assign mem_wdata_o = v_sel_data;

  assign cpu_rdata_o = m_data;
  assign cpu_hit_o   = hit;
  assign cpu_stall_o = cpu_req_i && !hit;
endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VICT_N = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_hit_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              main_hit,
  input logic              v_hit,
  input logic [VICT_N-1:0] v_hit_vec,
  input logic              swap_en,
  input logic              fill_en
);
  p_hit_no_mem_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |-> (cpu_req_i && !mem_req_o));

  p_fill_then_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en |=> (!cpu_req_i || cpu_hit_o));

  p_swap_no_mem_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_en |-> !mem_req_o);

  p_swap_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_en |=> (!cpu_req_i || cpu_hit_o));

  p_unique_home_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_hit && v_hit) && $onehot0(v_hit_vec));

  p_we_in_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  p_mem_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) &&
      $stable(mem_addr_o) && (!mem_we_o || $stable(mem_wdata_o))));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r10: assert (!mem_req_o && !cpu_hit_o);
    end
  end
endmodule

bind victim_dm_cache vc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VICT_N(VICT_N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_hit_o   (cpu_hit_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .main_hit    (main_hit),
  .v_hit       (v_hit),
  .v_hit_vec   (v_hit_vec),
  .swap_en     (swap_en),
  .fill_en     (fill_en)
);

// File: tb/victim_dm_cache_tb_top.sv
`timescale 1ns/1ps
module victim_dm_cache_tb_top;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int LAT = 2;
  localparam int MEM = 1 << AW;
  localparam logic [31:0] D1 = 32'hDEAD_0001;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [7:0]    cyc;
  } vec_t;

  // cycles: 0 array hit, 1 side-store hit, 3 clean miss
  localparam vec_t VEC [8] = '{
    '{1'b0, 12'h001, 32'h0, 8'd3},
    '{1'b0, 12'h001, 32'h0, 8'd0},
    '{1'b1, 12'h001, D1,    8'd0},
    '{1'b0, 12'h009, 32'h0, 8'd3},
    '{1'b0, 12'h001, 32'h0, 8'd1},
    '{1'b0, 12'h009, 32'h0, 8'd1},
    '{1'b0, 12'h002, 32'h0, 8'd3},
    '{1'b0, 12'h002, 32'h0, 8'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          hit, stall, mreq, mwe;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mwdata;
  logic          mack = 1'b0;
  logic [DW-1:0] mrdata = '0;

  logic [DW-1:0] mem_m  [MEM];
  logic [DW-1:0] golden [MEM];
  int n_chk = 0, n_fail = 0;
  int cnt = 0, rd_cnt = 0, wb_cnt = 0;
  logic [AW-1:0] wb_addr = '0;
  logic [DW-1:0] wb_data = '0;

  always #5 clk = ~clk;

  victim_dm_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .cpu_hit_o(hit), .cpu_stall_o(stall),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_ack_i(mack), .mem_rdata_i(mrdata)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      mack = 1'b0;
      cnt  = 0;
    end else if (mack) begin
      mack = 1'b0;
      cnt  = 0;
    end else if (mreq) begin
      cnt++;
      if (cnt == LAT) begin
        mack = 1'b1;
        if (mwe) begin
          mem_m[maddr] = mwdata;
          wb_cnt++;
          wb_addr = maddr;
          wb_data = mwdata;
        end else begin
          mrdata = mem_m[maddr];
          rd_cnt++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int cyc, output logic st0);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    st0 = stall;
    cyc = 0;
    while (!hit && cyc < 200) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rd = rdata;
    if (w) golden[a] = d;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input int exp_cyc);
    logic [DW-1:0] r;
    int c;
    logic s;
    access(1'b0, a, '0, r, c, s);
    chk({tag, " cycles"}, 32'(c), 32'(exp_cyc));
    chk({tag, " data"}, r, golden[a]);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    int c;
    logic s;
    for (int i = 0; i < MEM; i++) begin
      mem_m[i]  = 32'(i) ^ 32'h3C3C_0000;
      golden[i] = 32'(i) ^ 32'h3C3C_0000;
    end
    repeat (3) @(negedge clk);
    #1;
    // R10: quiet while in reset
    chk("R10 hit in reset", 32'(hit), 0);
    chk("R10 mem_req in reset", 32'(mreq), 0);
    chk("R11 stall idle", 32'(stall), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R11 vector walk
    for (int k = 0; k < 8; k++) begin
      access(VEC[k].we, VEC[k].addr, VEC[k].wdata, r, c, s);
      chk($sformatf("R1/R3/R5 vec%0d cycles", k), 32'(c), 32'(VEC[k].cyc));
      if (!VEC[k].we) chk($sformatf("R1 vec%0d data", k), r, golden[VEC[k].addr]);
      chk($sformatf("R11 vec%0d stall", k), 32'(s), 32'(VEC[k].cyc != 0));
    end
    chk("R2 R3 read count", 32'(rd_cnt), 3);
    chk("R4 R5 no write-back", 32'(wb_cnt), 0);

    // R6 fill the side store with index-1 conflicts
    rd_chk("R6 fill 011", 12'h011, 3);
    rd_chk("R6 fill 019", 12'h019, 3);
    rd_chk("R6 fill 021", 12'h021, 3);
    chk("R4 no write while filling", 32'(wb_cnt), 0);

    // R8: oldest entry holds dirty 001
    rd_chk("R8 dirty push-out", 12'h029, 6);
    chk("R8 write count", 32'(wb_cnt), 1);
    chk("R8 write addr", 32'(wb_addr), 32'h001);
    chk("R8 write data", wb_data, D1);

    // R7: next oldest is clean 009
    rd_chk("R7 refetch 001", 12'h001, 3);
    chk("R7 clean drop no write", 32'(wb_cnt), 1);
    rd_chk("R6 side hit 011", 12'h011, 1);
    rd_chk("R6 side hit 019", 12'h019, 1);
    rd_chk("R7 009 was dropped", 12'h009, 3);
    chk("R7 write count", 32'(wb_cnt), 1);

    // R10: reset mid-run empties both stores
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 mem_req during reset", 32'(mreq), 0);
    rst_n = 1'b1;
    rd_chk("R10 miss after reset", 12'h001, 3);
    rd_chk("R10 hit after refill", 12'h001, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule